// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block gives a processor reach into the configuration space of downstream devices through two narrow ports instead of a large memory window. The processor first loads a 32-bit selector through the address port. The selector holds an enable flag, a bus number, a device/function number and a register offset. Each later access to the data port becomes one configuration read or write toward the target that the selector names.

On every data-port access the bridge merges the low two port-address bits into the register offset. It then clips the byte count so that the access stays inside the 256-byte space. Before anything goes downstream, it checks the enable flag and the presence information for the selected target. A disabled access or a missing target is answered locally: a read returns all ones and a write is dropped. Only accesses that pass these checks go out as a request under a valid/ready handshake. The processor side stalls until the completion comes back.

Top module: `cfg_port_bridge`

## Requirements
- R1: The selector register changes only on an address-port write at port offset 0 with a length of 4 bytes; an address-port write at any other offset or length completes and leaves the selector unchanged.
- R2: An address-port read returns the stored 32-bit selector unchanged and completes one cycle after acceptance.
- R3: After reset the selector is 0. An address-port read then returns 0, and a data-port read returns 0xFFFFFFFF with no downstream request.
- R4: With selector bit 31 clear, a data-port read returns 0xFFFFFFFF, a data-port write is dropped, no downstream request is issued, and the access completes one cycle after acceptance.
- R5: The downstream bus number is selector bits 23:16 and the device/function number is selector bits 15:8.
- R6: The downstream register offset is selector bits 7:0 bitwise ORed with the 2-bit data-port address.
- R7: The downstream byte length is the requested length (1, 2 or 4), reduced to 256 minus the offset when fewer bytes than requested remain. It is never 0.
- R8: When the target presence input is low, a data-port read returns 0xFFFFFFFF and a data-port write is dropped, with no downstream request.
- R9: When the target is flagged as an orphaned function (a non-zero function added while function 0 is absent), it is treated as absent as in R8.
- R10: The downstream valid stays high, with its fields held, until ready is seen. The processor-side ready stays low until the downstream completion returns, and it is a single-cycle pulse.
- R11: Read data from a target is right-aligned. Bytes at and above the clipped length read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_sel_data_i | input | 1 | 0 = address port, 1 = data port |
| cpu_addr_i | input | 2 | Byte address within the selected port |
| cpu_len_i | input | 3 | Access length in bytes: 1, 2 or 4 |
| cpu_wdata_i | input | 32 | Write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Read data, valid with cpu_ready_o |
| tgt_bus_o | output | 8 | Bus number decoded from the selector |
| tgt_devfn_o | output | 8 | Device/function number decoded from the selector |
| tgt_present_i | input | 1 | A device answers at tgt_bus_o/tgt_devfn_o |
| tgt_orphan_i | input | 1 | The selected function is orphaned and hidden |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request accepted |
| dn_we_o | output | 1 | Downstream write |
| dn_off_o | output | 8 | Effective register offset |
| dn_len_o | output | 3 | Clipped byte length |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_rsp_valid_i | input | 1 | Downstream completion pulse |
| dn_rdata_i | input | 32 | Downstream read data |

## Verification
The hardest case to reach is the length clip. It occurs only when the selector offset sits in the last few bytes of the space and a port address ORed into it pushes the access across the 256-byte end. The stimulus loads a selector with offset 0xFD and then issues full-word reads at port addresses 0 and 2. These must go out as a 3-byte access at 0xFD and a 1-byte access at 0xFF, each with matching zeroed upper bytes. Orphaned and absent targets are produced by a presence model in the bench that is keyed on the decoded device/function number. The bench also counts downstream requests, so every locally answered access can be shown to issue none.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } xact_st_e;
endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_o <= '0;
    else if (wr_en_i) sel_o <= wdata_i;
  end
endmodule

// File: rtl/cfg_offset_len.sv
module cfg_offset_len #(
  parameter int SPACE_BYTES = 256,
  parameter int OFF_W       = 8,
  parameter int LEN_W       = 3
) (
  input  logic [OFF_W-1:0] base_off_i,
  input  logic [1:0]       port_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic [OFF_W-1:0] eff_off_o,
  output logic [LEN_W-1:0] eff_len_o
);
  localparam int REM_W = OFF_W + 1;

  logic [REM_W-1:0] left;

  assign eff_off_o = base_off_i | OFF_W'(port_addr_i);
  assign left      = REM_W'(SPACE_BYTES) - {1'b0, eff_off_o};
  assign eff_len_o = (REM_W'(req_len_i) > left) ? LEN_W'(left) : req_len_i;
endmodule

// File: rtl/cfg_xact_ctrl.sv
module cfg_xact_ctrl
  import cfg_bridge_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OFF_W  = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic              cpu_sel_data_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [LEN_W-1:0]  cpu_len_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  input  logic [WORD_W-1:0] sel_i,
  input  logic [OFF_W-1:0]  eff_off_i,
  input  logic [LEN_W-1:0]  eff_len_i,
  input  logic              tgt_present_i,
  input  logic              tgt_orphan_i,
  input  logic              dn_ready_i,
  input  logic              dn_rsp_valid_i,
  input  logic [WORD_W-1:0] dn_rdata_i,
  output logic              sel_wr_o,
  output logic              idle_o,
  output logic              cpu_ready_o,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              dn_valid_o,
  output logic              dn_we_o,
  output logic [OFF_W-1:0]  dn_off_o,
  output logic [LEN_W-1:0]  dn_len_o,
  output logic [WORD_W-1:0] dn_wdata_o
);
  localparam int NBYTES = WORD_W / 8;

  xact_st_e          st_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rd_mask;
  logic              accept;
  logic              tgt_ok;

  assign accept   = (st_q == ST_IDLE) && cpu_req_i;
  assign tgt_ok   = sel_i[WORD_W-1] && tgt_present_i && !tgt_orphan_i;
  assign sel_wr_o = accept && !cpu_sel_data_i && cpu_we_i &&
                    (cpu_addr_i == 2'd0) && (cpu_len_i == LEN_W'(NBYTES));

  // keep byte b only when it lies below the clipped length
  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign rd_mask[b*8 +: 8] = {8{LEN_W'(b) < dn_len_o}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rdata_q    <= '0;
      dn_we_o    <= 1'b0;
      dn_off_o   <= '0;
      dn_len_o   <= '0;
      dn_wdata_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (!cpu_sel_data_i) begin
            rdata_q <= sel_i;
            st_q    <= ST_DONE;
          end else if (!tgt_ok) begin
            rdata_q <= '1;
            st_q    <= ST_DONE;
          end else begin
            dn_we_o    <= cpu_we_i;
            dn_off_o   <= eff_off_i;
            dn_len_o   <= eff_len_i;
            dn_wdata_o <= cpu_wdata_i;
            st_q       <= ST_REQ;
          end
        end
        ST_REQ: if (dn_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (dn_rsp_valid_i) begin
          if (!dn_we_o) rdata_q <= dn_rdata_i & rd_mask;
          st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign cpu_ready_o = (st_q == ST_DONE);
  assign cpu_rdata_o = rdata_q;
  assign dn_valid_o  = (st_q == ST_REQ);
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int SPACE_BYTES = 256,
  parameter int WORD_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic              cpu_sel_data_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [2:0]        cpu_len_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic [7:0]        tgt_bus_o,
  output logic [7:0]        tgt_devfn_o,
  input  logic              tgt_present_i,
  input  logic              tgt_orphan_i,
  output logic              dn_valid_o,
  input  logic              dn_ready_i,
  output logic              dn_we_o,
  output logic [7:0]        dn_off_o,
  output logic [2:0]        dn_len_o,
  output logic [WORD_W-1:0] dn_wdata_o,
  input  logic              dn_rsp_valid_i,
  input  logic [WORD_W-1:0] dn_rdata_i
);
  localparam int OFF_W     = $clog2(SPACE_BYTES);
  localparam int LEN_W     = 3;
  localparam int DEVFN_LSB = 8;
  localparam int BUS_LSB   = 16;

  logic [WORD_W-1:0] sel_w;
  logic              sel_wr_w;
  logic              idle_w;
  logic [OFF_W-1:0]  eff_off_w;
  logic [LEN_W-1:0]  eff_len_w;

  assign tgt_bus_o   = sel_w[BUS_LSB +: 8];
  assign tgt_devfn_o = sel_w[DEVFN_LSB +: 8];

  cfg_sel_reg #(.WORD_W(WORD_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (sel_wr_w),
    .wdata_i (cpu_wdata_i),
    .sel_o   (sel_w)
  );

  cfg_offset_len #(.SPACE_BYTES(SPACE_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_offlen (
    .base_off_i  (sel_w[OFF_W-1:0]),
    .port_addr_i (cpu_addr_i),
    .req_len_i   (cpu_len_i),
    .eff_off_o   (eff_off_w),
    .eff_len_o   (eff_len_w)
  );

  cfg_xact_ctrl #(.WORD_W(WORD_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cpu_req_i      (cpu_req_i),
    .cpu_we_i       (cpu_we_i),
    .cpu_sel_data_i (cpu_sel_data_i),
    .cpu_addr_i     (cpu_addr_i),
    .cpu_len_i      (cpu_len_i),
    .cpu_wdata_i    (cpu_wdata_i),
    .sel_i          (sel_w),
    .eff_off_i      (eff_off_w),
    .eff_len_i      (eff_len_w),
    .tgt_present_i  (tgt_present_i),
    .tgt_orphan_i   (tgt_orphan_i),
    .dn_ready_i     (dn_ready_i),
    .dn_rsp_valid_i (dn_rsp_valid_i),
    .dn_rdata_i     (dn_rdata_i),
    .sel_wr_o       (sel_wr_w),
    .idle_o         (idle_w),
    .cpu_ready_o    (cpu_ready_o),
    .cpu_rdata_o    (cpu_rdata_o),
    .dn_valid_o     (dn_valid_o),
    .dn_we_o        (dn_we_o),
    .dn_off_o       (dn_off_o),
    .dn_len_o       (dn_len_o),
    .dn_wdata_o     (dn_wdata_o)
  );
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
  parameter int WORD_W      = 32,
  parameter int OFF_W       = 8,
  parameter int LEN_W       = 3,
  parameter int SPACE_BYTES = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic              cpu_sel_data_i,
  input logic [1:0]        cpu_addr_i,
  input logic [LEN_W-1:0]  cpu_len_i,
  input logic              idle_i,
  input logic [WORD_W-1:0] sel_i,
  input logic              cpu_ready_i,
  input logic              dn_valid_i,
  input logic              dn_ready_i,
  input logic              dn_we_i,
  input logic [OFF_W-1:0]  dn_off_i,
  input logic [LEN_W-1:0]  dn_len_i,
  input logic              tgt_present_i,
  input logic              tgt_orphan_i
);
  logic full_addr_wr;
  assign full_addr_wr = idle_i && cpu_req_i && !cpu_sel_data_i && cpu_we_i &&
                        (cpu_addr_i == 2'd0) && (cpu_len_i == LEN_W'(WORD_W / 8));

  AST_SEL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_addr_wr |=> $stable(sel_i)); // R1

  AST_DN_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_i |-> sel_i[WORD_W-1]); // R4

  AST_LEN_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_i |-> (dn_len_i != '0) &&
      (({1'b0, dn_off_i} + (OFF_W+1)'(dn_len_i)) <= (OFF_W+1)'(SPACE_BYTES))); // R7

  AST_DN_TARGET_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_i |-> tgt_present_i && !tgt_orphan_i); // R8

  AST_DN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_i && !dn_ready_i |=> dn_valid_i && $stable(dn_off_i) &&
      $stable(dn_len_i) && $stable(dn_we_i)); // R10

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_i |=> !cpu_ready_i); // R10
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(
  .WORD_W(WORD_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .SPACE_BYTES(SPACE_BYTES)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_req_i      (cpu_req_i),
  .cpu_we_i       (cpu_we_i),
  .cpu_sel_data_i (cpu_sel_data_i),
  .cpu_addr_i     (cpu_addr_i),
  .cpu_len_i      (cpu_len_i),
  .idle_i         (idle_w),
  .sel_i          (sel_w),
  .cpu_ready_i    (cpu_ready_o),
  .dn_valid_i     (dn_valid_o),
  .dn_ready_i     (dn_ready_i),
  .dn_we_i        (dn_we_o),
  .dn_off_i       (dn_off_o),
  .dn_len_i       (dn_len_o),
  .tgt_present_i  (tgt_present_i),
  .tgt_orphan_i   (tgt_orphan_i)
);

// File: tb/cfg_port_bridge_tb_top.sv
module cfg_port_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_sd = 1'b0;
  logic [1:0]  cpu_addr = '0;
  logic [2:0]  cpu_len = 3'd4;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic [7:0]  tgt_bus, tgt_devfn;
  logic        tgt_present, tgt_orphan;
  logic        dn_valid, dn_ready, dn_we, dn_rsp;
  logic [7:0]  dn_off;
  logic [2:0]  dn_len;
  logic [31:0] dn_wdata;
  localparam logic [31:0] MODEL_RD = 32'hA1B2_C3D4;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  cfg_port_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_sel_data_i(cpu_sd),
    .cpu_addr_i(cpu_addr), .cpu_len_i(cpu_len), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .tgt_bus_o(tgt_bus), .tgt_devfn_o(tgt_devfn),
    .tgt_present_i(tgt_present), .tgt_orphan_i(tgt_orphan),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_we_o(dn_we),
    .dn_off_o(dn_off), .dn_len_o(dn_len), .dn_wdata_o(dn_wdata),
    .dn_rsp_valid_i(dn_rsp), .dn_rdata_i(MODEL_RD)
  );

  // target model: presence keyed on devfn, 2-cycle accept stall, 1-cycle response delay
  assign tgt_present = (tgt_devfn == 8'h08) || (tgt_devfn == 8'h19) || (tgt_devfn == 8'h21);
  assign tgt_orphan  = (tgt_devfn == 8'h21);

  int          m_cnt;
  logic [1:0]  m_wait;
  logic        m_pend;
  logic [7:0]  m_bus, m_dfn, m_off;
  logic [2:0]  m_len;
  logic        m_we;
  logic [31:0] m_wd;

  assign dn_ready = dn_valid && (m_wait == 2'd2);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_wait <= '0; m_pend <= 1'b0; dn_rsp <= 1'b0;
    end else begin
      dn_rsp <= m_pend;
      m_pend <= 1'b0;
      if (dn_valid && !dn_ready) m_wait <= m_wait + 2'd1;
      if (dn_valid && dn_ready) begin
        m_wait <= '0; m_pend <= 1'b1; m_cnt <= m_cnt + 1;
        m_bus <= tgt_bus; m_dfn <= tgt_devfn; m_off <= dn_off;
        m_len <= dn_len; m_we <= dn_we; m_wd <= dn_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input int tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic sd, input logic we, input logic [1:0] ad,
                        input logic [2:0] ln, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_sd = sd; cpu_we = we; cpu_addr = ad; cpu_len = ln; cpu_wdata = wd; cpu_req = 1'b1;
    cyc = 0;
    rd  = '0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      cyc++;
      if (cpu_ready) break;
    end
    if (!cpu_ready) begin
      n_run++; n_fail++;
      $display("FAIL R10 actual=%h expected=%h (access timeout)", 32'd0, 32'd1);
    end
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  typedef struct packed {
    logic        sd;  logic        we;  logic [1:0] ad;  logic [2:0] ln;
    logic [31:0] wd;  logic        ck;  logic [31:0] rd; logic       rq;
    logic [7:0]  bus; logic [7:0]  dfn; logic [7:0] off; logic [2:0] el;
    logic [3:0]  cyc; logic [3:0]  tag;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,2'd0,3'd4,32'h8000_0810,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},  // R1 load
    '{1'b0,1'b0,2'd0,3'd4,32'h0,        1'b1,32'h8000_0810,1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd2},  // R2
    '{1'b0,1'b1,2'd1,3'd4,32'h1234_5678,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},  // R1 offset!=0
    '{1'b0,1'b1,2'd0,3'd2,32'h0000_1111,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},  // R1 len!=4
    '{1'b0,1'b0,2'd0,3'd4,32'h0,        1'b1,32'h8000_0810,1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},  // R1 kept
    '{1'b1,1'b0,2'd2,3'd2,32'h0,        1'b1,32'h0000_C3D4,1'b1,8'h00,8'h08,8'h12,3'd2,4'd6,4'd6},  // R6 R11
    '{1'b1,1'b0,2'd3,3'd1,32'h0,        1'b1,32'h0000_00D4,1'b1,8'h00,8'h08,8'h13,3'd1,4'd6,4'd11}, // R11
    '{1'b1,1'b1,2'd0,3'd4,32'hCAFE_F00D,1'b0,32'h0,        1'b1,8'h00,8'h08,8'h10,3'd4,4'd6,4'd5},  // R5 write
    '{1'b0,1'b1,2'd0,3'd4,32'h8000_08FD,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},
    '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'h00B2_C3D4,1'b1,8'h00,8'h08,8'hFD,3'd3,4'd6,4'd7},  // R7 clip to 3
    '{1'b1,1'b0,2'd2,3'd4,32'h0,        1'b1,32'h0000_00D4,1'b1,8'h00,8'h08,8'hFF,3'd1,4'd6,4'd7},  // R7 clip to 1
    '{1'b0,1'b1,2'd0,3'd4,32'h0000_0810,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},
    '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'hFFFF_FFFF,1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd4},  // R4 read
    '{1'b1,1'b1,2'd0,3'd4,32'h5555_AAAA,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd4},  // R4 write
    '{1'b0,1'b1,2'd0,3'd4,32'h8000_2010,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},
    '{1'b1,1'b0,2'd0,3'd4,32'h0,        1'b1,32'hFFFF_FFFF,1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd8},  // R8 read
    '{1'b1,1'b1,2'd0,3'd4,32'h1111_2222,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd8},  // R8 write
    '{1'b0,1'b1,2'd0,3'd4,32'h8000_2110,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},
    '{1'b1,1'b0,2'd1,3'd1,32'h0,        1'b1,32'hFFFF_FFFF,1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd9},  // R9 read
    '{1'b1,1'b1,2'd0,3'd4,32'h3333_4444,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd9},  // R9 write
    '{1'b0,1'b1,2'd0,3'd4,32'h8005_1904,1'b0,32'h0,        1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd1},
    '{1'b1,1'b0,2'd1,3'd1,32'h0,        1'b1,32'h0000_00D4,1'b1,8'h05,8'h19,8'h05,3'd1,4'd6,4'd5},  // R5 R6
    '{1'b0,1'b0,2'd0,3'd4,32'h0,        1'b1,32'h8005_1904,1'b0,8'h00,8'h00,8'h00,3'd0,4'd1,4'd2}   // R2
  };

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R10 actual=%h expected=%h (watchdog)", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          cyc;
    int          c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    access(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, rd, cyc);
    chk(rd == 32'h0, 3, rd, 32'h0);
    c0 = m_cnt;
    access(1'b1, 1'b0, 2'd0, 3'd4, 32'h0, rd, cyc);
    chk(rd == 32'hFFFF_FFFF, 3, rd, 32'hFFFF_FFFF);
    chk(m_cnt == c0, 3, m_cnt, c0);

    for (int v = 0; v < NV; v++) begin
      c0 = m_cnt;
      access(VEC[v].sd, VEC[v].we, VEC[v].ad, VEC[v].ln, VEC[v].wd, rd, cyc);
      if (VEC[v].ck) chk(rd == VEC[v].rd, int'(VEC[v].tag), rd, VEC[v].rd);
      // R10: completion latency (1 for local answers, 6 through the stalling target)
      chk(cyc == int'(VEC[v].cyc), 10, cyc, 32'(VEC[v].cyc));
      chk(m_cnt == c0 + int'(VEC[v].rq), int'(VEC[v].tag), m_cnt, c0 + int'(VEC[v].rq));
      if (VEC[v].rq) begin
        chk(m_bus == VEC[v].bus, 5, m_bus, VEC[v].bus);
        chk(m_dfn == VEC[v].dfn, 5, m_dfn, VEC[v].dfn);
        chk(m_off == VEC[v].off, 6, m_off, VEC[v].off);
        chk(m_len == VEC[v].el, 7, m_len, VEC[v].el);
        chk(m_we == VEC[v].we, int'(VEC[v].tag), m_we, VEC[v].we);
        if (VEC[v].we) chk(m_wd == VEC[v].wd, 5, m_wd, VEC[v].wd);
      end
    end

    // R3: reset in the middle of operation clears the selector again
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, rd, cyc);
    chk(rd == 32'h0, 3, rd, 32'h0);
    c0 = m_cnt;
    access(1'b1, 1'b1, 2'd0, 3'd4, 32'hDEAD_BEEF, rd, cyc);
    chk(m_cnt == c0, 3, m_cnt, c0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule